// File: doc/BRIEF.md
# Ring-Qualified Translation Lookup with Access Check

This block translates one virtual address per request through a small set-associative translation buffer. Each way holds a fixed number of entries and covers pages of its own size; the way's page size decides which address bits pick the entry and which bits pass straight through as the page offset. A stored entry counts as a hit only when its page tag matches and its address-space identifier is both nonzero and present in a four-byte ring register, whose byte position gives the privilege ring of that entry.

After a single hit the block compares the entry's ring against the requester's privilege level, decodes the entry's four-bit attribute into read, write, execute and cache-mode rights, strips the rights that do not apply to the access side (instruction or data), and checks that the requested kind of access is allowed. The result, a cause code (zero for success), the physical address and the rights, appears one clock after the request. Entries and the ring register are loaded through plain write ports.

Top module: `tlbx_lookup`

## Requirements
- R1: The ring register resets to 0x04030201 and can be rewritten; byte k (k = 0 at bits 7:0 up to k = 3 at bits 31:24) holds the identifier that owns ring k. An entry's ring is the lowest k whose byte equals its identifier; with no matching byte the entry has no ring.
- R2: A way hits only when the entry selected by the address bits just above the way's page offset has a stored page equal to the address with its offset bits cleared, a nonzero identifier, and an identifier that has a ring. Writing an entry with identifier 0 makes it unable to hit.
- R3: With no hitting way the cause is 16 for an instruction fetch (kind 2) and 24 for a load (kind 0) or store (kind 1).
- R4: With two or more hitting ways the cause is 17 for a fetch and 25 for a load or store.
- R5: After a single hit, an entry ring numerically below the request's privilege input gives cause 18 for a fetch and 26 for a load or store.
- R6: Attributes 0 to 11 grant read, add execute when bit 0 is set and write when bit 1 is set, and give cache mode bits 3:2 (0 bypass, 1 write-back, 2 write-through). Attribute 13 grants read and write with cache mode 3 (isolate). Attributes 12, 14 and 15 grant nothing with cache mode 0.
- R7: A fetch reports no read or write right and a load or store reports no execute right. A fetch without execute gives cause 20, a load without read 28, a store without write 29.
- R8: On success the physical address is the entry's physical page ORed with the request address bits that lie inside the way's page offset.
- R9: Results appear one clock after a request: the response valid output follows the request valid input with one cycle delay, and the physical address output keeps its previous value when a nonzero cause is reported.
- R10: Causes are ranked miss or multi-hit first, then privilege, then access right. On a miss, multi-hit or privilege fault all rights and the cache mode read as zero; on an access-right fault the side-masked rights are still reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_wr_en | input | 1 | Load the ring register |
| ring_wr_data | input | 32 | New ring register value, byte k for ring k |
| ent_wr_en | input | 1 | Write one translation entry |
| ent_wr_way | input | clog2(NUM_WAYS) | Way of the entry written |
| ent_wr_idx | input | clog2(ENTRIES) | Index of the entry written |
| ent_wr_vpage | input | 32 | Virtual page tag (offset bits zero) |
| ent_wr_ppage | input | 32 | Physical page base |
| ent_wr_asid | input | 8 | Address-space identifier, 0 marks the entry unused |
| ent_wr_attr | input | 4 | Access attribute |
| req_valid | input | 1 | A lookup is requested this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch (3 acts as load) |
| req_priv | input | 2 | Current privilege level of the requester |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_cause | output | 6 | Cause code, 0 on success |
| rsp_paddr | output | 32 | Physical address, held on a fault |
| rsp_read | output | 1 | Read right |
| rsp_write | output | 1 | Write right |
| rsp_exec | output | 1 | Execute right |
| rsp_cache | output | 2 | Cache mode: 0 bypass, 1 write-back, 2 write-through, 3 isolate |

## Verification
A corrupted entry field or ring register byte turns up at the very next response: a wrong tag or identifier flips the cause between success, miss and multi-hit, a wrong ring turns into a spurious or missing privilege cause, and a wrong attribute changes the rights or the prohibited cause. A bad physical page shows only on a successful lookup, because the address output holds on faults, so the stimulus follows every fault case with a success to expose it. The one-cycle response timing and the address hold are also watched continuously by properties beside the output registers.

// File: rtl/tlbx_pkg.sv
// Package: shared widths, access kinds, rights record, entry record and
// cause codes for the ring-qualified translation lookup.
// Assumes a 32-bit address space on both virtual and physical sides.
package tlbx_pkg;

    localparam int ADDR_W   = 32;
    localparam int ASID_W   = 8;
    localparam int RING_CNT = 4;
    localparam int RING_W   = 2;
    localparam int ATTR_W   = 4;
    localparam int CAUSE_W  = 6;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CM_BYPASS  = 2'd0,
        CM_WBACK   = 2'd1,
        CM_WTHRU   = 2'd2,
        CM_ISOLATE = 2'd3
    } cache_mode_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        ex;
        cache_mode_e cache;
    } rights_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vpage;
        logic [ADDR_W-1:0] ppage;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    localparam logic [CAUSE_W-1:0] CAUSE_OK         = 6'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_I_MISS     = 6'd16;
    localparam logic [CAUSE_W-1:0] CAUSE_I_MULTI    = 6'd17;
    localparam logic [CAUSE_W-1:0] CAUSE_I_PRIV     = 6'd18;
    localparam logic [CAUSE_W-1:0] CAUSE_I_DENY     = 6'd20;
    localparam logic [CAUSE_W-1:0] CAUSE_D_MISS     = 6'd24;
    localparam logic [CAUSE_W-1:0] CAUSE_D_MULTI    = 6'd25;
    localparam logic [CAUSE_W-1:0] CAUSE_D_PRIV     = 6'd26;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_DENY  = 6'd28;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29;

endpackage

// File: rtl/tlbx_way.sv
// Module: one way of the translation buffer.
// Holds ENTRIES entries of one page size, selects an entry with the address
// bits just above the page offset, and reports whether its page tag matches
// and its identifier is nonzero. Assumes ENTRIES is a power of two.
module tlbx_way
    import tlbx_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_data,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output tlb_entry_t        lk_entry,
    output logic              lk_tag_eq,
    output logic [ADDR_W-1:0] lk_off_mask
);

    localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

    tlb_entry_t       slots [ENTRIES];
    logic [IDX_W-1:0] lk_idx;

    // Entry storage: cleared to unused on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    // Index selection and tag comparison for the current lookup address.
    always_comb begin
        lk_idx      = lk_vaddr[PAGE_SHIFT +: IDX_W];
        lk_entry    = slots[lk_idx];
        lk_off_mask = OFF_MASK;
        lk_tag_eq   = (lk_entry.vpage == (lk_vaddr & ~OFF_MASK))
                    && (lk_entry.asid != '0);
    end

endmodule

// File: rtl/tlbx_ring_map.sv
// Module: maps an address-space identifier to a privilege ring by searching
// the four bytes of the ring register; the lowest matching byte wins.
// Purely combinational.
module tlbx_ring_map
    import tlbx_pkg::*;
(
    input  logic [ASID_W-1:0]          asid,
    input  logic [RING_CNT*ASID_W-1:0] ring_asids,
    output logic [RING_W-1:0]          ring,
    output logic                       found
);

    // Scan from the highest ring down so the lowest match is left standing.
    always_comb begin
        ring  = '0;
        found = 1'b0;
        for (int r = RING_CNT - 1; r >= 0; r--) begin
            if (ring_asids[r*ASID_W +: ASID_W] == asid) begin
                ring  = RING_W'(r);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlbx_rights.sv
// Module: decodes an entry attribute into access rights and cache mode,
// removes the rights that do not belong to the access side, and reports
// whether the requested access kind is allowed. Combinational.
module tlbx_rights
    import tlbx_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  acc_kind_e         kind,
    output rights_t           rights,
    output logic              granted
);

    rights_t raw;

    // Attribute decode: low attributes give read plus optional exec/write.
    always_comb begin
        raw = '0;
        if (attr < 4'd12) begin
            raw.rd = 1'b1;
            raw.ex = attr[0];
            raw.wr = attr[1];
            unique case (attr[3:2])
                2'd0:    raw.cache = CM_BYPASS;
                2'd1:    raw.cache = CM_WBACK;
                default: raw.cache = CM_WTHRU;
            endcase
        end else if (attr == 4'd13) begin
            raw.rd    = 1'b1;
            raw.wr    = 1'b1;
            raw.cache = CM_ISOLATE;
        end
    end

    // Side masking and permission test for the requested access kind.
    always_comb begin
        rights = raw;
        if (kind == ACC_FETCH) begin
            rights.rd = 1'b0;
            rights.wr = 1'b0;
        end else begin
            rights.ex = 1'b0;
        end
        unique case (kind)
            ACC_FETCH: granted = rights.ex;
            ACC_STORE: granted = rights.wr;
            default:   granted = rights.rd;
        endcase
    end

endmodule

// File: rtl/tlbx_lookup.sv
// Module: ring-qualified translation lookup with access check (top).
// Looks a virtual address up in NUM_WAYS ways, qualifies each tag match by
// the ring register, ranks miss / multi-hit / privilege / access faults and
// registers cause, physical address and rights one cycle after req_valid.
// Assumes WAY_SHIFTS packs one 5-bit page shift per way, way 0 lowest.
module tlbx_lookup
    import tlbx_pkg::*;
#(
    parameter int                      NUM_WAYS   = 4,
    parameter int                      ENTRIES    = 4,
    parameter logic [NUM_WAYS*5-1:0]   WAY_SHIFTS = {5'd20, 5'd16, 5'd12, 5'd12},
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ring_wr_en,
    input  logic [RING_CNT*ASID_W-1:0] ring_wr_data,
    input  logic                       ent_wr_en,
    input  logic [WAY_W-1:0]           ent_wr_way,
    input  logic [IDX_W-1:0]           ent_wr_idx,
    input  logic [ADDR_W-1:0]          ent_wr_vpage,
    input  logic [ADDR_W-1:0]          ent_wr_ppage,
    input  logic [ASID_W-1:0]          ent_wr_asid,
    input  logic [ATTR_W-1:0]          ent_wr_attr,
    input  logic                       req_valid,
    input  logic [1:0]                 req_kind,
    input  logic [RING_W-1:0]          req_priv,
    input  logic [ADDR_W-1:0]          req_vaddr,
    output logic                       rsp_valid,
    output logic [CAUSE_W-1:0]         rsp_cause,
    output logic [ADDR_W-1:0]          rsp_paddr,
    output logic                       rsp_read,
    output logic                       rsp_write,
    output logic                       rsp_exec,
    output logic [1:0]                 rsp_cache
);

    localparam int CNT_W = $clog2(NUM_WAYS + 1);
    localparam logic [RING_CNT*ASID_W-1:0] RING_RESET = 32'h0403_0201;

    logic [RING_CNT*ASID_W-1:0] ring_asids_q;
    tlb_entry_t                 wr_data;
    tlb_entry_t                 way_ent  [NUM_WAYS];
    logic [ADDR_W-1:0]          way_mask [NUM_WAYS];
    logic [RING_W-1:0]          way_ring [NUM_WAYS];
    logic [NUM_WAYS-1:0]        way_tag_eq;
    logic [NUM_WAYS-1:0]        way_ring_ok;
    logic [NUM_WAYS-1:0]        way_hit;

    logic [CNT_W-1:0]  hit_cnt;
    logic [RING_W-1:0] sel_ring;
    logic [ATTR_W-1:0] sel_attr;
    logic [ADDR_W-1:0] sel_ppage;
    logic [ADDR_W-1:0] sel_mask;
    acc_kind_e         kind;
    rights_t           side_rights;
    logic              side_granted;
    logic [CAUSE_W-1:0] cause_n;
    rights_t           rights_n;
    logic [ADDR_W-1:0] paddr_n;

    assign kind    = acc_kind_e'(req_kind);
    assign wr_data = '{vpage: ent_wr_vpage, ppage: ent_wr_ppage,
                       asid: ent_wr_asid, attr: ent_wr_attr};

    // Ring register: reset to its fixed pattern, replaced whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_asids_q <= RING_RESET;
        end else if (ring_wr_en) begin
            ring_asids_q <= ring_wr_data;
        end
    end

    // One storage way and one ring lookup per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        localparam int SHIFT = int'(WAY_SHIFTS[w*5 +: 5]);

        tlbx_way #(
            .ENTRIES    (ENTRIES),
            .PAGE_SHIFT (SHIFT)
        ) u_way (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (ent_wr_en && (ent_wr_way == WAY_W'(w))),
            .wr_idx      (ent_wr_idx),
            .wr_data     (wr_data),
            .lk_vaddr    (req_vaddr),
            .lk_entry    (way_ent[w]),
            .lk_tag_eq   (way_tag_eq[w]),
            .lk_off_mask (way_mask[w])
        );

        tlbx_ring_map u_ring (
            .asid       (way_ent[w].asid),
            .ring_asids (ring_asids_q),
            .ring       (way_ring[w]),
            .found      (way_ring_ok[w])
        );

        assign way_hit[w] = way_tag_eq[w] & way_ring_ok[w];
    end

    // Hit count and OR-merge of the hitting way's fields.
    always_comb begin
        hit_cnt   = '0;
        sel_ring  = '0;
        sel_attr  = '0;
        sel_ppage = '0;
        sel_mask  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (way_hit[w]) begin
                hit_cnt   = hit_cnt + CNT_W'(1);
                sel_ring  = sel_ring  | way_ring[w];
                sel_attr  = sel_attr  | way_ent[w].attr;
                sel_ppage = sel_ppage | way_ent[w].ppage;
                sel_mask  = sel_mask  | way_mask[w];
            end
        end
    end

    tlbx_rights u_rights (
        .attr    (sel_attr),
        .kind    (kind),
        .rights  (side_rights),
        .granted (side_granted)
    );

    // Fault ranking: miss, multi-hit, privilege, then access right.
    always_comb begin
        rights_n = '0;
        paddr_n  = sel_ppage | (req_vaddr & sel_mask);
        if (hit_cnt == '0) begin
            cause_n = (kind == ACC_FETCH) ? CAUSE_I_MISS : CAUSE_D_MISS;
        end else if (hit_cnt > CNT_W'(1)) begin
            cause_n = (kind == ACC_FETCH) ? CAUSE_I_MULTI : CAUSE_D_MULTI;
        end else if (sel_ring < req_priv) begin
            cause_n = (kind == ACC_FETCH) ? CAUSE_I_PRIV : CAUSE_D_PRIV;
        end else begin
            rights_n = side_rights;
            if (side_granted) begin
                cause_n = CAUSE_OK;
            end else if (kind == ACC_FETCH) begin
                cause_n = CAUSE_I_DENY;
            end else if (kind == ACC_STORE) begin
                cause_n = CAUSE_STORE_DENY;
            end else begin
                cause_n = CAUSE_LOAD_DENY;
            end
        end
    end

    // Response registers; the address only moves on a successful lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            rsp_read  <= 1'b0;
            rsp_write <= 1'b0;
            rsp_exec  <= 1'b0;
            rsp_cache <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_cause <= cause_n;
                rsp_read  <= rights_n.rd;
                rsp_write <= rights_n.wr;
                rsp_exec  <= rights_n.ex;
                rsp_cache <= rights_n.cache;
                if (cause_n == CAUSE_OK) begin
                    rsp_paddr <= paddr_n;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_paddr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != CAUSE_OK) |-> $stable(rsp_paddr));

    assert_fetch_no_rw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == 2'd2) |-> (!rsp_read && !rsp_write));

    assert_data_no_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) != 2'd2) |-> !rsp_exec);

    assert_success_has_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == CAUSE_OK) |-> (rsp_read || rsp_write || rsp_exec));

    assert_fault_clears_rights_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_cause == CAUSE_I_MISS || rsp_cause == CAUSE_D_MISS ||
                       rsp_cause == CAUSE_I_MULTI || rsp_cause == CAUSE_D_MULTI ||
                       rsp_cause == CAUSE_I_PRIV || rsp_cause == CAUSE_D_PRIV))
        |-> (!rsp_read && !rsp_write && !rsp_exec && rsp_cache == 2'd0));

endmodule

// File: tb/tlbx_lookup_tb.sv
`timescale 1ns/1ps
module tlbx_lookup_tb;

    localparam logic [5:0] I_MISS = 6'd16, I_MULTI = 6'd17, I_PRIV = 6'd18, I_DENY = 6'd20;
    localparam logic [5:0] D_MISS = 6'd24, D_MULTI = 6'd25, D_PRIV = 6'd26;
    localparam logic [5:0] L_DENY = 6'd28, S_DENY = 6'd29;
    localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_IF = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  priv;
        logic [31:0] va;
        logic [5:0]  cause;
        logic [31:0] pa;
        logic [4:0]  flags;   // {read, write, exec, cache[1:0]}
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{K_LD, 2'd0, 32'h0000_1234, 6'd0,    32'h8000_0234, 5'b11001}, // R8 R6
        '{K_ST, 2'd0, 32'h0000_1ABC, 6'd0,    32'h8000_0ABC, 5'b11001}, // R6
        '{K_IF, 2'd0, 32'h0000_1000, 6'd0,    32'h8000_0000, 5'b00101}, // R7
        '{K_LD, 2'd1, 32'h0000_1010, D_PRIV,  32'h8000_0000, 5'b00000}, // R5
        '{K_IF, 2'd2, 32'h0000_2468, 6'd0,    32'h9000_0468, 5'b00100}, // R5 equal ring
        '{K_ST, 2'd0, 32'h0000_2000, S_DENY,  32'h9000_0468, 5'b10000}, // R7 R10
        '{K_IF, 2'd3, 32'h0000_2000, I_PRIV,  32'h9000_0468, 5'b00000}, // R5
        '{K_LD, 2'd1, 32'h0005_ABCD, 6'd0,    32'hA000_ABCD, 5'b10010}, // R8 R6
        '{K_IF, 2'd0, 32'h0005_0000, I_DENY,  32'hA000_ABCD, 5'b00010}, // R7
        '{K_ST, 2'd3, 32'h003F_FFFF, 6'd0,    32'hB00F_FFFF, 5'b11011}, // R6 isolate
        '{K_IF, 2'd0, 32'h0030_0000, I_DENY,  32'hB00F_FFFF, 5'b00011}, // R7
        '{K_LD, 2'd0, 32'h0000_3000, D_MULTI, 32'hB00F_FFFF, 5'b00000}, // R4
        '{K_IF, 2'd0, 32'h0000_3000, I_MULTI, 32'hB00F_FFFF, 5'b00000}, // R4
        '{K_LD, 2'd0, 32'h0000_0000, D_MISS,  32'hB00F_FFFF, 5'b00000}, // R2 unmapped id
        '{K_IF, 2'd0, 32'h0000_5000, I_MISS,  32'hB00F_FFFF, 5'b00000}, // R2 id zero
        '{K_LD, 2'd0, 32'h0006_0000, L_DENY,  32'hB00F_FFFF, 5'b00000}, // R6 attr 15
        '{K_LD, 2'd0, 32'h0000_7000, D_MISS,  32'hB00F_FFFF, 5'b00000}, // R3
        '{K_LD, 2'd3, 32'h0000_3000, D_MULTI, 32'hB00F_FFFF, 5'b00000}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ring_wr_en = 1'b0;
    logic [31:0] ring_wr_data = '0;
    logic        ent_wr_en = 1'b0;
    logic [1:0]  ent_wr_way = '0;
    logic [1:0]  ent_wr_idx = '0;
    logic [31:0] ent_wr_vpage = '0;
    logic [31:0] ent_wr_ppage = '0;
    logic [7:0]  ent_wr_asid = '0;
    logic [3:0]  ent_wr_attr = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_priv = '0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [5:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic        rsp_read, rsp_write, rsp_exec;
    logic [1:0]  rsp_cache;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tlbx_lookup u_dut (
        .clk(clk), .rst_n(rst_n),
        .ring_wr_en(ring_wr_en), .ring_wr_data(ring_wr_data),
        .ent_wr_en(ent_wr_en), .ent_wr_way(ent_wr_way), .ent_wr_idx(ent_wr_idx),
        .ent_wr_vpage(ent_wr_vpage), .ent_wr_ppage(ent_wr_ppage),
        .ent_wr_asid(ent_wr_asid), .ent_wr_attr(ent_wr_attr),
        .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv),
        .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
        .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_exec(rsp_exec),
        .rsp_cache(rsp_cache)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic put_entry(input logic [1:0] way, input logic [1:0] idx,
                             input logic [31:0] vp, input logic [31:0] pp,
                             input logic [7:0] id, input logic [3:0] attr);
        ent_wr_en = 1'b1; ent_wr_way = way; ent_wr_idx = idx;
        ent_wr_vpage = vp; ent_wr_ppage = pp; ent_wr_asid = id; ent_wr_attr = attr;
        @(negedge clk);
        ent_wr_en = 1'b0;
    endtask

    task automatic put_rings(input logic [31:0] v);
        ring_wr_en = 1'b1; ring_wr_data = v;
        @(negedge clk);
        ring_wr_en = 1'b0;
    endtask

    // Drive one request at a falling edge; response is read one cycle later.
    task automatic lookup(input logic [1:0] kind, input logic [1:0] priv, input logic [31:0] va);
        req_valid = 1'b1; req_kind = kind; req_priv = priv; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R9, R1 observed through ring lookups later)
        check("R9 reset valid", 32'(rsp_valid), 32'd0);
        check("R9 reset cause", 32'(rsp_cause), 32'd0);
        check("R9 reset paddr", rsp_paddr, 32'd0);
        check("R10 reset rights", 32'({rsp_read, rsp_write, rsp_exec, rsp_cache}), 32'd0);

        // Ways: 0 and 1 use 4 KiB pages, 2 uses 64 KiB, 3 uses 1 MiB.
        put_entry(2'd0, 2'd1, 32'h0000_1000, 32'h8000_0000, 8'd1, 4'd7);
        put_entry(2'd1, 2'd2, 32'h0000_2000, 32'h9000_0000, 8'd3, 4'd1);
        put_entry(2'd2, 2'd1, 32'h0005_0000, 32'hA000_0000, 8'd2, 4'd8);
        put_entry(2'd3, 2'd3, 32'h0030_0000, 32'hB000_0000, 8'd4, 4'd13);
        put_entry(2'd0, 2'd3, 32'h0000_3000, 32'hD000_0000, 8'd1, 4'd3);
        put_entry(2'd1, 2'd3, 32'h0000_3000, 32'hE000_0000, 8'd2, 4'd3);
        put_entry(2'd0, 2'd0, 32'h0000_0000, 32'hC000_0000, 8'd9, 4'd3);
        put_entry(2'd1, 2'd1, 32'h0000_5000, 32'hF000_0000, 8'd0, 4'd3);
        put_entry(2'd2, 2'd2, 32'h0006_0000, 32'h1000_0000, 8'd1, 4'd15);

        // Table walk: reset ring register 0x04030201 applies (R1).
        for (int i = 0; i < NVEC; i++) begin
            lookup(VECS[i].kind, VECS[i].priv, VECS[i].va);
            check($sformatf("R9 vec%0d valid", i), 32'(rsp_valid), 32'd1);
            check($sformatf("R3/R4/R5/R7 vec%0d cause", i), 32'(rsp_cause), 32'(VECS[i].cause));
            check($sformatf("R8/R9 vec%0d paddr", i), rsp_paddr, VECS[i].pa);
            check($sformatf("R6/R7/R10 vec%0d rights", i),
                  32'({rsp_read, rsp_write, rsp_exec, rsp_cache}), 32'(VECS[i].flags));
        end

        // R1: new ring register, id 9 in byte 2, id 1 in byte 3, id 3 gone.
        put_rings(32'h0109_0205);
        lookup(K_LD, 2'd2, 32'h0000_0040);
        check("R1 id9 ring2 cause", 32'(rsp_cause), 32'd0);
        check("R1 id9 ring2 paddr", rsp_paddr, 32'hC000_0040);
        check("R1 id9 rights", 32'({rsp_read, rsp_write, rsp_exec, rsp_cache}), 32'b11000);
        lookup(K_LD, 2'd3, 32'h0000_1000);
        check("R1 id1 ring3 cause", 32'(rsp_cause), 32'd0);
        lookup(K_IF, 2'd0, 32'h0000_2000);
        check("R1 id3 unmapped miss", 32'(rsp_cause), 32'(I_MISS));

        // R1: repeated id, lowest byte gives ring 0, below privilege 1.
        put_rings(32'h0101_0101);
        lookup(K_LD, 2'd1, 32'h0000_1000);
        check("R1 lowest byte wins", 32'(rsp_cause), 32'(D_PRIV));

        // R9: an idle cycle gives no response.
        @(negedge clk);
        check("R9 idle valid", 32'(rsp_valid), 32'd0);

        // R2: rewriting an entry with id 0 removes it.
        put_entry(2'd0, 2'd1, 32'h0000_1000, 32'h8000_0000, 8'd0, 4'd7);
        lookup(K_LD, 2'd0, 32'h0000_1000);
        check("R2 id zero miss", 32'(rsp_cause), 32'(D_MISS));

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule